// File: doc/BRIEF.md
# Ping-Pong Cell Operand Buffer

This block holds the operand and result words exchanged between a 64-cell compute array and the DMA engines that feed it. Storage is divided into sets. A set has one 32-bit word per cell and is read or written as a single 2048-bit vector on the array side. One set at a time is the active set. It supplies operands to the array and takes the array's results. Every other set is open to the DMA side through a 32-bit word port in the same cycles. Software fills one set by DMA while the array computes on another, then swaps the two roles.

A routing table sits between a set and the cell slots. Each table entry is 384 bits wide and holds one 6-bit field per cell slot. Field c names the set word that slot c reads, and the same field names the set word that slot c's result is written back into. A control strobe picks the active set and table entry in one cycle, and this also launches an operand read. Two small state machines drive the block. The array machine has states ARR_IDLE and ARR_FRESH. A select moves it to ARR_FRESH, and any cycle without a select returns it to ARR_IDLE. The DMA machine has states DMA_IDLE, DMA_RESP and DMA_BLOCK. A read of an inactive set moves it to DMA_RESP. An access to the active set moves it to DMA_BLOCK. A write, or no access, returns it to DMA_IDLE.

Top module: `pingpong_cell_buffer`

## Requirements
- R1: After reset, arr_rvalid, dma_rvalid and dma_conflict are low, arr_rdata is all zero, and the active set and entry are both 0. A DMA access to set 0 is therefore blocked.
- R2: A cycle with ctl_sel high makes ctl_set and ctl_entry the active set and entry. In the next cycle arr_rvalid is high for exactly that cycle, and cell slot c of arr_rdata (bits 32c+31 to 32c) holds word F(c) of the selected set.
- R3: F(c) is the 6-bit field at bits 6c+5 to 6c of the chosen table entry.
- R4: A cycle with arr_we high writes slot c of arr_wdata into word F(c) of the active set, with F(c) taken from the active entry. Words that no field names keep their value.
- R5: If several slots name the same word in a write-back, the highest-numbered slot's data is stored.
- R6: A DMA write (dma_en and dma_we high) to a set other than the active one stores dma_wdata at {dma_set, dma_word} in that cycle.
- R7: A DMA read (dma_en high, dma_we low) of a set other than the active one returns the word on dma_rdata in the next cycle, with dma_rvalid high for that cycle.
- R8: A DMA access whose dma_set equals the active set stores nothing and returns no data. dma_conflict is high in the next cycle.
- R9: An array write-back and a DMA write to a different set in the same cycle both take effect.
- R10: arr_rdata keeps its value in every cycle that follows a cycle without ctl_sel, including after write-backs.
- R11: A table write changes the entry for selects in later cycles. A select in the same cycle uses the previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sel | input | 1 | Select strobe: latch active set and entry, read operands |
| ctl_set | input | SET_W | Set to make active |
| ctl_entry | input | ENT_W | Routing table entry to make active |
| tab_we | input | 1 | Routing table write enable |
| tab_addr | input | ENT_W | Routing table entry written |
| tab_wdata | input | NCELLS*IDX_W | New entry, 6-bit field per slot |
| arr_we | input | 1 | Result write-back into the active set |
| arr_wdata | input | NCELLS*WORD_W | Results, one word per cell slot |
| arr_rdata | output | NCELLS*WORD_W | Routed operands, one word per cell slot |
| arr_rvalid | output | 1 | Operands refreshed this cycle |
| dma_en | input | 1 | DMA word access request |
| dma_we | input | 1 | 1 write, 0 read |
| dma_set | input | SET_W | Set addressed by DMA |
| dma_word | input | IDX_W | Word within the set |
| dma_wdata | input | WORD_W | DMA write data |
| dma_rdata | output | WORD_W | DMA read data |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_conflict | output | 1 | Previous DMA access hit the active set and was dropped |

## Verification
Identity, reversed and random routing entries tell a correct per-slot field decode apart from swapped or shifted fields. An entry whose fields all name one word exposes the wrong winner when slots collide. DMA accesses aimed at the active set, and at idle sets in the same cycle as a write-back, separate correct blocking from leaks between the two sides. A seeded random mix of selects, write-backs, table writes and DMA traffic, checked against a word-level model, covers the orderings that the directed cases miss.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

    typedef enum logic {
        ARR_IDLE  = 1'b0,
        ARR_FRESH = 1'b1
    } arr_state_e;

    typedef enum logic [1:0] {
        DMA_IDLE  = 2'd0,
        DMA_RESP  = 2'd1,
        DMA_BLOCK = 2'd2
    } dma_state_e;

endpackage

// File: rtl/pp_route_table.sv
module pp_route_table #(
    parameter  int NCELLS = 64,
    parameter  int NTAB   = 16,
    localparam int IDX_W  = $clog2(NCELLS),
    localparam int ENT_W  = $clog2(NTAB),
    localparam int TAB_W  = NCELLS * IDX_W
) (
    input  logic                             clk,
    input  logic                             we,
    input  logic [ENT_W-1:0]                 waddr,
    input  logic [TAB_W-1:0]                 wdata,
    input  logic [ENT_W-1:0]                 ent_a,
    output logic [NCELLS-1:0][IDX_W-1:0]     fld_a,
    input  logic [ENT_W-1:0]                 ent_b,
    output logic [NCELLS-1:0][IDX_W-1:0]     fld_b
);

    logic [TAB_W-1:0] tab [NTAB];

    always_ff @(posedge clk) begin
        if (we) begin
            tab[waddr] <= wdata;
        end
    end

    // field c of an entry sits at bits IDX_W*c and up
    assign fld_a = tab[ent_a];
    assign fld_b = tab[ent_b];

endmodule

// File: rtl/pp_set_store.sv
module pp_set_store #(
    parameter  int NSETS  = 4,
    parameter  int NCELLS = 64,
    parameter  int WORD_W = 32,
    localparam int SET_W  = $clog2(NSETS),
    localparam int IDX_W  = $clog2(NCELLS),
    localparam int ADDR_W = SET_W + IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [SET_W-1:0]                  rd_set,
    input  logic [NCELLS-1:0][IDX_W-1:0]      rd_fld,
    output logic [NCELLS-1:0][WORD_W-1:0]     rd_data,
    input  logic                              wb_en,
    input  logic [SET_W-1:0]                  wb_set,
    input  logic [NCELLS-1:0][IDX_W-1:0]      wb_fld,
    input  logic [NCELLS-1:0][WORD_W-1:0]     wb_data,
    input  logic                              d_rd,
    input  logic                              d_wr,
    input  logic [ADDR_W-1:0]                 d_addr,
    input  logic [WORD_W-1:0]                 d_wdata,
    output logic [WORD_W-1:0]                 d_rdata
);

    logic [WORD_W-1:0] mem    [NSETS*NCELLS];
    logic [WORD_W-1:0] routed [NCELLS];

    // write-back: ascending slot order, so the last (highest) slot wins a shared word
    always_ff @(posedge clk) begin
        if (wb_en) begin
            for (int c = 0; c < NCELLS; c++) begin
                mem[{wb_set, wb_fld[c]}] <= wb_data[c];
            end
        end
        if (d_wr) begin
            mem[d_addr] <= d_wdata;
        end
    end

    for (genvar g = 0; g < NCELLS; g++) begin : g_route
        assign routed[g] = mem[{rd_set, rd_fld[g]}];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            for (int c = 0; c < NCELLS; c++) begin
                rd_data[c] <= routed[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_rdata <= '0;
        end else if (d_rd) begin
            d_rdata <= mem[d_addr];
        end
    end

    AST_SETS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && d_wr) |-> (wb_set != d_addr[ADDR_W-1:IDX_W])); // R9

endmodule

// File: rtl/pp_dma_port.sv
module pp_dma_port
    import pp_buf_pkg::*;
#(
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             dma_we,
    input  logic [SET_W-1:0] dma_set,
    input  logic [SET_W-1:0] act_set,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             rvalid,
    output logic             conflict
);

    dma_state_e st, st_nx;
    logic       hit;

    assign hit    = dma_en && (dma_set == act_set);
    assign mem_rd = dma_en && !dma_we && !hit;
    assign mem_wr = dma_en &&  dma_we && !hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= DMA_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = DMA_IDLE;
        unique case (st)
            DMA_IDLE, DMA_RESP, DMA_BLOCK: begin
                if (hit) begin
                    st_nx = DMA_BLOCK;
                end else if (mem_rd) begin
                    st_nx = DMA_RESP;
                end
            end
            default: st_nx = DMA_IDLE;
        endcase
    end

    always_comb begin
        rvalid   = 1'b0;
        conflict = 1'b0;
        unique case (st)
            DMA_IDLE:  ;
            DMA_RESP:  rvalid   = 1'b1;
            DMA_BLOCK: conflict = 1'b1;
            default:   ;
        endcase
    end

    AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !dma_we && dma_set != act_set) |=> (rvalid && !conflict)); // R7
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dma_we) |=> !rvalid); // R6
    AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dma_set == act_set) |=> (conflict && !rvalid)); // R8
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> $past(dma_en)); // R8

endmodule

// File: rtl/pingpong_cell_buffer.sv
module pingpong_cell_buffer
    import pp_buf_pkg::*;
#(
    parameter  int NSETS  = 4,
    parameter  int NCELLS = 64,
    parameter  int WORD_W = 32,
    parameter  int NTAB   = 16,
    localparam int SET_W  = $clog2(NSETS),
    localparam int IDX_W  = $clog2(NCELLS),
    localparam int ENT_W  = $clog2(NTAB),
    localparam int TAB_W  = NCELLS * IDX_W,
    localparam int ARR_W  = NCELLS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_sel,
    input  logic [SET_W-1:0]  ctl_set,
    input  logic [ENT_W-1:0]  ctl_entry,
    input  logic              tab_we,
    input  logic [ENT_W-1:0]  tab_addr,
    input  logic [TAB_W-1:0]  tab_wdata,
    input  logic              arr_we,
    input  logic [ARR_W-1:0]  arr_wdata,
    output logic [ARR_W-1:0]  arr_rdata,
    output logic              arr_rvalid,
    input  logic              dma_en,
    input  logic              dma_we,
    input  logic [SET_W-1:0]  dma_set,
    input  logic [IDX_W-1:0]  dma_word,
    input  logic [WORD_W-1:0] dma_wdata,
    output logic [WORD_W-1:0] dma_rdata,
    output logic              dma_rvalid,
    output logic              dma_conflict
);

    arr_state_e st, st_nx;
    logic [SET_W-1:0] act_set;
    logic [ENT_W-1:0] act_ent;
    logic [NCELLS-1:0][IDX_W-1:0] rd_fld, wb_fld;
    logic [NCELLS-1:0][WORD_W-1:0] rd_vec;
    logic mem_rd, mem_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ARR_IDLE;
            act_set <= '0;
            act_ent <= '0;
        end else begin
            st <= st_nx;
            if (ctl_sel) begin
                act_set <= ctl_set;
                act_ent <= ctl_entry;
            end
        end
    end

    always_comb begin
        st_nx = ARR_IDLE;
        unique case (st)
            ARR_IDLE:  st_nx = ctl_sel ? ARR_FRESH : ARR_IDLE;
            ARR_FRESH: st_nx = ctl_sel ? ARR_FRESH : ARR_IDLE;
            default:   st_nx = ARR_IDLE;
        endcase
    end

    always_comb begin
        arr_rvalid = 1'b0;
        unique case (st)
            ARR_IDLE:  arr_rvalid = 1'b0;
            ARR_FRESH: arr_rvalid = 1'b1;
            default:   arr_rvalid = 1'b0;
        endcase
    end

    pp_route_table #(.NCELLS(NCELLS), .NTAB(NTAB)) u_table (
        .clk   (clk),
        .we    (tab_we),
        .waddr (tab_addr),
        .wdata (tab_wdata),
        .ent_a (ctl_entry),
        .fld_a (rd_fld),
        .ent_b (act_ent),
        .fld_b (wb_fld)
    );

    pp_dma_port #(.SET_W(SET_W)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_en   (dma_en),
        .dma_we   (dma_we),
        .dma_set  (dma_set),
        .act_set  (act_set),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .rvalid   (dma_rvalid),
        .conflict (dma_conflict)
    );

    pp_set_store #(.NSETS(NSETS), .NCELLS(NCELLS), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (ctl_sel),
        .rd_set  (ctl_set),
        .rd_fld  (rd_fld),
        .rd_data (rd_vec),
        .wb_en   (arr_we),
        .wb_set  (act_set),
        .wb_fld  (wb_fld),
        .wb_data (arr_wdata),
        .d_rd    (mem_rd),
        .d_wr    (mem_wr),
        .d_addr  ({dma_set, dma_word}),
        .d_wdata (dma_wdata),
        .d_rdata (dma_rdata)
    );

    assign arr_rdata = rd_vec;

    AST_OPND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel |=> arr_rvalid); // R2
    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rvalid |-> $past(ctl_sel)); // R2
    AST_OPND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_sel |=> $stable(arr_rdata)); // R10

endmodule

// File: tb/pingpong_cell_buffer_bench.sv
module pingpong_cell_buffer_bench;

    localparam int NSETS  = 4;
    localparam int NCELLS = 64;
    localparam int WORD_W = 32;
    localparam int NTAB   = 16;
    localparam int SET_W  = $clog2(NSETS);
    localparam int IDX_W  = $clog2(NCELLS);
    localparam int ENT_W  = $clog2(NTAB);
    localparam int TAB_W  = NCELLS * IDX_W;
    localparam int ARR_W  = NCELLS * WORD_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ctl_sel;
    logic [SET_W-1:0]  ctl_set;
    logic [ENT_W-1:0]  ctl_entry;
    logic              tab_we;
    logic [ENT_W-1:0]  tab_addr;
    logic [TAB_W-1:0]  tab_wdata;
    logic              arr_we;
    logic [ARR_W-1:0]  arr_wdata;
    logic [ARR_W-1:0]  arr_rdata;
    logic              arr_rvalid;
    logic              dma_en;
    logic              dma_we;
    logic [SET_W-1:0]  dma_set;
    logic [IDX_W-1:0]  dma_word;
    logic [WORD_W-1:0] dma_wdata;
    logic [WORD_W-1:0] dma_rdata;
    logic              dma_rvalid;
    logic              dma_conflict;

    always #2 clk = ~clk;

    pingpong_cell_buffer #(.NSETS(NSETS), .NCELLS(NCELLS), .WORD_W(WORD_W), .NTAB(NTAB))
    u_pingpong_cell_buffer (
        .clk(clk), .rst_n(rst_n),
        .ctl_sel(ctl_sel), .ctl_set(ctl_set), .ctl_entry(ctl_entry),
        .tab_we(tab_we), .tab_addr(tab_addr), .tab_wdata(tab_wdata),
        .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .arr_rvalid(arr_rvalid),
        .dma_en(dma_en), .dma_we(dma_we), .dma_set(dma_set), .dma_word(dma_word),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_rvalid(dma_rvalid),
        .dma_conflict(dma_conflict)
    );

    // word-level model
    logic [WORD_W-1:0] mm [NSETS*NCELLS];
    logic [TAB_W-1:0]  mt [NTAB];
    int                m_set;
    int                m_ent;
    logic [ARR_W-1:0]  m_arr;
    int                n_chk;
    int                n_bad;

    function automatic int fld(input logic [TAB_W-1:0] e, input int c);
        return int'(e[c*IDX_W +: IDX_W]);
    endfunction

    function automatic logic [ARR_W-1:0] rnd_arr();
        logic [ARR_W-1:0] r;
        for (int c = 0; c < NCELLS; c++) r[c*WORD_W +: WORD_W] = $urandom;
        return r;
    endfunction

    function automatic logic [TAB_W-1:0] rnd_ent();
        logic [TAB_W-1:0] r;
        for (int c = 0; c < NCELLS; c++) r[c*IDX_W +: IDX_W] = IDX_W'($urandom);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_arr(input string tag, input logic [ARR_W-1:0] act, input logic [ARR_W-1:0] exp);
        int bad = -1;
        for (int c = NCELLS - 1; c >= 0; c--)
            if (act[c*WORD_W +: WORD_W] !== exp[c*WORD_W +: WORD_W]) bad = c;
        if (bad < 0) chk(1'b1, tag, 64'd0, 64'd0);
        else chk(1'b0, tag, 64'(act[bad*WORD_W +: WORD_W]), 64'(exp[bad*WORD_W +: WORD_W]));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // one clock: drive at negedge, predict, check at next negedge
    task automatic step(input bit sel, input int ss, input int se,
                        input bit wb, input logic [ARR_W-1:0] wbd,
                        input bit dm, input bit dwe, input int ds, input int dw, input logic [31:0] dwd,
                        input bit tw, input int ta, input logic [TAB_W-1:0] td);
        bit xc, xrv;
        logic [31:0] xrd;
        logic [ARR_W-1:0] xarr;
        ctl_sel = sel; ctl_set = SET_W'(ss); ctl_entry = ENT_W'(se);
        arr_we = wb; arr_wdata = wbd;
        dma_en = dm; dma_we = dwe; dma_set = SET_W'(ds); dma_word = IDX_W'(dw); dma_wdata = dwd;
        tab_we = tw; tab_addr = ENT_W'(ta); tab_wdata = td;
        xc  = dm && (ds == m_set);
        xrv = dm && !dwe && !xc;
        xrd = mm[ds*NCELLS + dw];
        xarr = m_arr;
        if (sel) for (int c = 0; c < NCELLS; c++)
            xarr[c*WORD_W +: WORD_W] = mm[ss*NCELLS + fld(mt[se], c)];
        if (wb) for (int c = 0; c < NCELLS; c++)
            mm[m_set*NCELLS + fld(mt[m_ent], c)] = wbd[c*WORD_W +: WORD_W];
        if (dm && dwe && !xc) mm[ds*NCELLS + dw] = dwd;
        if (tw) mt[ta] = td;
        if (sel) begin m_set = ss; m_ent = se; end
        m_arr = xarr;
        @(posedge clk);
        @(negedge clk);
        ctl_sel = 1'b0; arr_we = 1'b0; dma_en = 1'b0; tab_we = 1'b0;
        chk(arr_rvalid == sel, "R2 operand valid", 64'(arr_rvalid), 64'(sel));
        if (sel) chk_arr("R2 routed operands", arr_rdata, xarr);
        else     chk_arr("R10 operands held", arr_rdata, xarr);
        chk(dma_conflict == xc, "R8 conflict flag", 64'(dma_conflict), 64'(xc));
        chk(dma_rvalid == xrv, "R7 read valid", 64'(dma_rvalid), 64'(xrv));
        if (xrv) chk(dma_rdata === xrd, "R7 read data", 64'(dma_rdata), 64'(xrd));
    endtask

    task automatic sel_t(input int s, input int e);
        step(1, s, e, 0, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask
    task automatic wbk_t(input logic [ARR_W-1:0] d);
        step(0, 0, 0, 1, d, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask
    task automatic dwr_t(input int s, input int w, input logic [31:0] d);
        step(0, 0, 0, 0, '0, 1, 1, s, w, d, 0, 0, '0);
    endtask
    task automatic drd_t(input int s, input int w);
        step(0, 0, 0, 0, '0, 1, 0, s, w, 0, 0, 0, '0);
    endtask
    task automatic twr_t(input int a, input logic [TAB_W-1:0] d);
        step(0, 0, 0, 0, '0, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [ARR_W-1:0] d;
        logic [TAB_W-1:0] e;
        logic [31:0] keep;
        void'($urandom(32'd20240611));
        n_chk = 0; n_bad = 0; m_set = 0; m_ent = 0; m_arr = '0;
        rst_n = 1'b0; ctl_sel = 0; ctl_set = '0; ctl_entry = '0; tab_we = 0; tab_addr = '0;
        tab_wdata = '0; arr_we = 0; arr_wdata = '0; dma_en = 0; dma_we = 0; dma_set = '0;
        dma_word = '0; dma_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(arr_rvalid == 1'b0, "R1 arr_rvalid low", 64'(arr_rvalid), 0);
        chk(dma_rvalid == 1'b0, "R1 dma_rvalid low", 64'(dma_rvalid), 0);
        chk(dma_conflict == 1'b0, "R1 conflict low", 64'(dma_conflict), 0);
        chk_arr("R1 operands zero", arr_rdata, '0);
        drd_t(0, 0);
        chk(dma_conflict == 1'b1, "R1 set 0 active after reset", 64'(dma_conflict), 1);

        // tables: 0 identity, 1 reversed, 3 all fields 5, others random
        for (int t = 0; t < NTAB; t++) begin
            for (int c = 0; c < NCELLS; c++) begin
                if (t == 0) e[c*IDX_W +: IDX_W] = IDX_W'(c);
                else if (t == 1) e[c*IDX_W +: IDX_W] = IDX_W'(NCELLS - 1 - c);
                else if (t == 3) e[c*IDX_W +: IDX_W] = IDX_W'(5);
                else e[c*IDX_W +: IDX_W] = IDX_W'($urandom);
            end
            twr_t(t, e);
        end

        // fill memory by DMA (R6): sets 1.. while 0 active, then set 0 while 1 active
        for (int s = 1; s < NSETS; s++)
            for (int w = 0; w < NCELLS; w++) dwr_t(s, w, $urandom);
        sel_t(1, 0);
        for (int w = 0; w < NCELLS; w++) dwr_t(0, w, $urandom);

        // R3 field layout
        sel_t(2, 0);
        chk(arr_rdata[31:0] === mm[2*NCELLS + 0], "R3 identity slot 0", 64'(arr_rdata[31:0]), 64'(mm[2*NCELLS]));
        sel_t(2, 1);
        chk(arr_rdata[31:0] === mm[2*NCELLS + 63], "R3 reversed slot 0", 64'(arr_rdata[31:0]), 64'(mm[2*NCELLS + 63]));
        sel_t(3, 2);

        // R4 / R5 collision write-back
        sel_t(2, 3);
        keep = mm[2*NCELLS + 6];
        d = rnd_arr();
        wbk_t(d);
        sel_t(1, 0);
        drd_t(2, 5);
        chk(dma_rdata === d[63*WORD_W +: WORD_W], "R5 highest slot wins", 64'(dma_rdata), 64'(d[63*WORD_W +: WORD_W]));
        drd_t(2, 6);
        chk(dma_rdata === keep, "R4 unnamed word kept", 64'(dma_rdata), 64'(keep));

        // R4 reversed write-back then identity read
        sel_t(3, 1);
        wbk_t(rnd_arr());
        sel_t(3, 0);

        // R6 write then read
        sel_t(1, 0);
        dwr_t(3, 10, 32'hA5A5_0F0F);
        drd_t(3, 10);
        chk(dma_rdata === 32'hA5A5_0F0F, "R6 dma write stored", 64'(dma_rdata), 64'hA5A5_0F0F);

        // R8 blocked write to active set 1
        keep = mm[1*NCELLS + 7];
        dwr_t(1, 7, ~keep);
        sel_t(1, 0);
        chk(arr_rdata[7*WORD_W +: WORD_W] === keep, "R8 blocked write", 64'(arr_rdata[7*WORD_W +: WORD_W]), 64'(keep));
        drd_t(1, 7);

        // R9 concurrent write-back and DMA write
        d = rnd_arr();
        step(0, 0, 0, 1, d, 1, 1, 2, 33, 32'h1234_5678, 0, 0, '0);
        drd_t(2, 33);
        chk(dma_rdata === 32'h1234_5678, "R9 dma side landed", 64'(dma_rdata), 64'h1234_5678);
        sel_t(1, 0);
        chk_arr("R9 array side landed", arr_rdata, d);

        // R10 operands held over a write-back
        wbk_t(rnd_arr());

        // R11 table write same cycle as select
        e = rnd_ent();
        step(1, 2, 4, 0, '0, 0, 0, 0, 0, 0, 1, 4, e);
        sel_t(2, 4);
        chk(arr_rdata[31:0] === mm[2*NCELLS + fld(e, 0)], "R11 new entry used", 64'(arr_rdata[31:0]),
            64'(mm[2*NCELLS + fld(e, 0)]));

        // seeded random mix
        for (int i = 0; i < 400; i++) begin
            bit sl = ($urandom % 4) == 0;
            bit wb = ($urandom % 4) == 0;
            bit dm = ($urandom % 2) == 0;
            bit tw = ($urandom % 8) == 0;
            step(sl, int'($urandom % NSETS), int'($urandom % NTAB),
                 wb, rnd_arr(),
                 dm, bit'($urandom % 2), int'($urandom % NSETS), int'($urandom % NCELLS), $urandom,
                 tw, int'($urandom % NTAB), rnd_ent());
        end

        summary();
        $finish;
    end

endmodule